// File: doc/BRIEF.md
# Core and Package Idle-State Resolver

This block turns idle requests from the hardware threads of a multi-core processor into a resolved idle state for each core, and then into one idle state for the whole package. By default there are four cores with two threads each. A thread asks to go idle with a one-cycle request pulse that carries an opcode. The opcode names the source of the request: a halt, a monitor-wait with a depth hint, or a read of one of two legacy level registers. The thread stays in the idle state it entered until its wake input is raised.

A core is only as deep as its shallowest thread. The package then takes the shallowest core as its request and limits that request by a platform permission input. The package can resolve to C0, C3 or C6. When the platform allows only C3, a C6 request is demoted to C3. The block also reports whether the shared last-level cache can still be snooped, and it gives a one-cycle strobe whenever the package state changes.

Idle states are coded 3 bits wide: C0=0, C1=1, C1E=2, C3=3, C6=4. A numerically lower code is a shallower state. Request opcodes are HALT=0, WAIT_C1=1, WAIT_C3=2, WAIT_C6=3, LEVEL2_READ=4 and LEVEL3_READ=5. Codes 6 and 7 are reserved. Platform permission is coded NONE=0, UP_TO_C3=1, and UP_TO_C6 for 2 or 3.

Top module: `cstate_resolver`

Each thread runs a small state machine with the states THR_C0, THR_C1, THR_C1E, THR_C3 and THR_C6. Its transitions are:
- REQUEST: THR_C0 goes to the state the opcode selects.
- WAKE: any idle state goes back to THR_C0.
- HOLD: in every other case the state does not change.

The package stage has the states PKG_C0, PKG_C3 and PKG_C6. Each cycle it picks its next state from the resolved core states and the permission, so it can move directly between any two of these states.

## Requirements
- R1: After reset, every core state and the package state read C0 (code 0), the cache-snoopable output is 1 and the change strobe is 0.
- R2: A HALT (op 0) or WAIT_C1 (op 1) request moves the thread to C1 (code 1) when c1e_en is 0, and to C1E (code 2) when c1e_en is 1.
- R3: WAIT_C3 (op 2) and LEVEL2_READ (op 4) move the thread to C3 (code 3). WAIT_C6 (op 3) and LEVEL3_READ (op 5) move it to C6 (code 4).
- R4: Each core state equals the numerically lowest state among that core's threads. A core therefore reaches C1 or C1E only when all of its threads are at that depth or deeper.
- R5: The package resolves to C0 when the lowest core state is C0, C1 or C1E, or when the permission is NONE (0).
- R6: When the lowest core state is C3 and the permission is 1 or higher, the package resolves to C3 (code 3).
- R7: When every core is in C6, the package resolves to C6 (code 4) if the permission is 2 or 3. It resolves to C3 if the permission is 1.
- R8: The cache-snoopable output is 0 exactly when the package is in C6. It is 1 in package C3 and in package C0.
- R9: Raising a thread's wake input returns that thread, its core and the package to C0 in the next cycle.
- R10: A request is ignored when the thread is not in C0, and a request with a reserved opcode (6 or 7) is ignored.
- R11: The change strobe is high for exactly the one cycle in which the registered package state differs from its previous value.
- R12: All outputs are registered. A request, a wake or a change of permission is visible on the outputs one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_CORES*THREADS_PER_CORE | One-cycle idle request pulse, one bit per thread |
| req_op | input | 3*NUM_CORES*THREADS_PER_CORE | Request opcode for each thread; thread t uses bits [3t+2:3t] |
| wake | input | NUM_CORES*THREADS_PER_CORE | Wake for each thread |
| c1e_en | input | 1 | When set, halt and C1 waits resolve to C1E |
| plat_allow | input | 2 | Deepest package state the platform permits |
| core_state | output | 3*NUM_CORES | Resolved state of each core; core c uses bits [3c+2:3c] |
| pkg_state | output | 3 | Resolved package state |
| llc_snoop | output | 1 | Shared cache can be snooped |
| pkg_chg | output | 1 | One-cycle strobe on a package state change |

## Verification
The thread registers cannot be seen at the ports, so the bench reads them through the core states. If a thread register is stuck, the core output stays at the wrong depth as soon as the thread's partner goes deeper. If a wake is dropped, the core, the package and the snoop flag all stay deep in the cycle right after the wake, where the bench expects C0. If the package stage picks the wrong state, it shows one clock after a change of permission or after the last core settles. A missed demotion to C3 also drops the snoop flag in that same cycle.

// File: rtl/cstres_pkg.sv
package cstres_pkg;

    typedef enum logic [2:0] {
        CS_C0  = 3'd0,
        CS_C1  = 3'd1,
        CS_C1E = 3'd2,
        CS_C3  = 3'd3,
        CS_C6  = 3'd4
    } cstate_e;

    localparam int unsigned CS_W = 3;
    localparam int unsigned OP_W = 3;

    localparam logic [OP_W-1:0] OP_HALT  = 3'd0;
    localparam logic [OP_W-1:0] OP_WAIT1 = 3'd1;
    localparam logic [OP_W-1:0] OP_WAIT3 = 3'd2;
    localparam logic [OP_W-1:0] OP_WAIT6 = 3'd3;
    localparam logic [OP_W-1:0] OP_LVL2  = 3'd4;
    localparam logic [OP_W-1:0] OP_LVL3  = 3'd5;

    localparam logic [1:0] PERMIT_NONE = 2'd0;
    localparam logic [1:0] PERMIT_C3   = 2'd1;
    localparam logic [1:0] PERMIT_C6   = 2'd2;

    function automatic logic [CS_W-1:0] shallower(input logic [CS_W-1:0] a,
                                                  input logic [CS_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cstres_thread.sv
module cstres_thread
    import cstres_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [OP_W-1:0] req_op,
    input  logic            wake,
    input  logic            c1e_en,
    output logic [CS_W-1:0] state_next
);

    cstate_e state_q;
    cstate_e state_d;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_C0: begin
                if (req_valid && !wake) begin
                    case (req_op)
                        OP_HALT, OP_WAIT1: state_d = c1e_en ? CS_C1E : CS_C1;
                        OP_WAIT3, OP_LVL2: state_d = CS_C3;
                        OP_WAIT6, OP_LVL3: state_d = CS_C6;
                        default:           state_d = CS_C0;
                    endcase
                end
            end
            CS_C1, CS_C1E, CS_C3, CS_C6: begin
                if (wake) begin
                    state_d = CS_C0;
                end
            end
            default: state_d = CS_C0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_C0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_next = state_d;

endmodule

// File: rtl/cstres_core.sv
module cstres_core
    import cstres_pkg::*;
#(
    parameter int unsigned THREADS_PER_CORE = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [THREADS_PER_CORE*CS_W-1:0] thr_next,
    output logic [CS_W-1:0]                  core_next,
    output logic [CS_W-1:0]                  core_q
);

    // Shallowest thread wins
    always_comb begin
        core_next = thr_next[CS_W-1:0];
        for (int i = 1; i < int'(THREADS_PER_CORE); i++) begin
            core_next = shallower(core_next, thr_next[i*CS_W +: CS_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= CS_C0;
        end else begin
            core_q <= core_next;
        end
    end

endmodule

// File: rtl/cstres_pkgstate.sv
module cstres_pkgstate
    import cstres_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES*CS_W-1:0] core_next,
    input  logic [1:0]                plat_allow,
    output logic [CS_W-1:0]           pkg_q,
    output logic                      snoop_q,
    output logic                      chg_q
);

    logic [CS_W-1:0] lowest;
    cstate_e         pkg_d;
    cstate_e         pkg_r;

    always_comb begin
        lowest = core_next[CS_W-1:0];
        for (int c = 1; c < int'(NUM_CORES); c++) begin
            lowest = shallower(lowest, core_next[c*CS_W +: CS_W]);
        end
    end

    // Package next-state: request capped by permission
    always_comb begin
        pkg_d = CS_C0;
        unique case (lowest)
            CS_C0, CS_C1, CS_C1E: pkg_d = CS_C0;
            CS_C3: pkg_d = (plat_allow != PERMIT_NONE) ? CS_C3 : CS_C0;
            CS_C6: begin
                if (plat_allow >= PERMIT_C6) begin
                    pkg_d = CS_C6;
                end else if (plat_allow == PERMIT_C3) begin
                    pkg_d = CS_C3;
                end else begin
                    pkg_d = CS_C0;
                end
            end
            default: pkg_d = CS_C0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkg_r <= CS_C0;
        end else begin
            pkg_r <= pkg_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snoop_q <= 1'b1;
            chg_q   <= 1'b0;
        end else begin
            snoop_q <= (pkg_d != CS_C6);
            chg_q   <= (pkg_d != pkg_r);
        end
    end

    assign pkg_q = pkg_r;

endmodule

// File: rtl/cstate_resolver.sv
module cstate_resolver
    import cstres_pkg::*;
#(
    parameter int unsigned NUM_CORES        = 4,
    parameter int unsigned THREADS_PER_CORE = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NUM_CORES*THREADS_PER_CORE-1:0]       req_valid,
    input  logic [3*NUM_CORES*THREADS_PER_CORE-1:0]     req_op,
    input  logic [NUM_CORES*THREADS_PER_CORE-1:0]       wake,
    input  logic                                        c1e_en,
    input  logic [1:0]                                  plat_allow,
    output logic [3*NUM_CORES-1:0]                      core_state,
    output logic [2:0]                                  pkg_state,
    output logic                                        llc_snoop,
    output logic                                        pkg_chg
);

    localparam int unsigned NUM_THREADS = NUM_CORES * THREADS_PER_CORE;

    logic [NUM_THREADS*CS_W-1:0] thr_next;
    logic [NUM_CORES*CS_W-1:0]   core_next;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        cstres_thread u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[t]),
            .req_op     (req_op[t*OP_W +: OP_W]),
            .wake       (wake[t]),
            .c1e_en     (c1e_en),
            .state_next (thr_next[t*CS_W +: CS_W])
        );
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        cstres_core #(
            .THREADS_PER_CORE (THREADS_PER_CORE)
        ) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .thr_next  (thr_next[c*THREADS_PER_CORE*CS_W +: THREADS_PER_CORE*CS_W]),
            .core_next (core_next[c*CS_W +: CS_W]),
            .core_q    (core_state[c*CS_W +: CS_W])
        );
    end

    cstres_pkgstate #(
        .NUM_CORES (NUM_CORES)
    ) u_pkg (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_next  (core_next),
        .plat_allow (plat_allow),
        .pkg_q      (pkg_state),
        .snoop_q    (llc_snoop),
        .chg_q      (pkg_chg)
    );

endmodule

// File: rtl/cstres_checker.sv
module cstres_checker #(
    parameter int unsigned NUM_CORES        = 4,
    parameter int unsigned THREADS_PER_CORE = 2
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [NUM_CORES*THREADS_PER_CORE-1:0]   wake,
    input logic [1:0]                              plat_allow,
    input logic [3*NUM_CORES-1:0]                  core_state,
    input logic [2:0]                              pkg_state,
    input logic                                    llc_snoop,
    input logic                                    pkg_chg
);

    logic past_valid;
    logic all_c6;
    logic all_c3_or_deeper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_valid <= 1'b0;
        end else begin
            past_valid <= 1'b1;
        end
    end

    always_comb begin
        all_c6           = 1'b1;
        all_c3_or_deeper = 1'b1;
        for (int c = 0; c < int'(NUM_CORES); c++) begin
            if (core_state[c*3 +: 3] != 3'd4) all_c6 = 1'b0;
            if (core_state[c*3 +: 3] < 3'd3)  all_c3_or_deeper = 1'b0;
        end
    end

    a_r8_snoop_off_in_c6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state == 3'd4) |-> !llc_snoop);

    a_r8_snoop_on_outside_c6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state != 3'd4) |-> llc_snoop);

    a_r11_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (pkg_chg == (pkg_state != $past(pkg_state))));

    a_r9_wake_pkg_c0: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake) |=> (pkg_state == 3'd0));

    a_r6_deep_pkg_needs_deep_cores: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state != 3'd0) |-> all_c3_or_deeper);

    a_r7_c6_needs_all_cores_and_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && pkg_state == 3'd4) |-> (all_c6 && $past(plat_allow) >= 2'd2));

    a_r5_no_grant_keeps_c0: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(plat_allow) == 2'd0) |-> (pkg_state == 3'd0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_wake_chk
        a_r9_wake_core_c0: assert property (@(posedge clk) disable iff (!rst_n)
            (|wake[c*THREADS_PER_CORE +: THREADS_PER_CORE]) |=> (core_state[c*3 +: 3] == 3'd0));
    end

endmodule

bind cstate_resolver cstres_checker #(
    .NUM_CORES        (NUM_CORES),
    .THREADS_PER_CORE (THREADS_PER_CORE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake       (wake),
    .plat_allow (plat_allow),
    .core_state (core_state),
    .pkg_state  (pkg_state),
    .llc_snoop  (llc_snoop),
    .pkg_chg    (pkg_chg)
);

// File: tb/cstate_resolver_tb.sv
module cstate_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int TPC = 2;
    localparam int NT = NC * TPC;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NT-1:0]   req_valid;
    logic [3*NT-1:0] req_op;
    logic [NT-1:0]   wake;
    logic            c1e_en;
    logic [1:0]      plat_allow;
    logic [3*NC-1:0] core_state;
    logic [2:0]      pkg_state;
    logic            llc_snoop;
    logic            pkg_chg;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cstate_resolver #(.NUM_CORES(NC), .THREADS_PER_CORE(TPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .wake(wake), .c1e_en(c1e_en), .plat_allow(plat_allow),
        .core_state(core_state), .pkg_state(pkg_state),
        .llc_snoop(llc_snoop), .pkg_chg(pkg_chg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int core_of(input int c);
        return int'(core_state[c*3 +: 3]);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic req(input int t, input int op);
        req_valid[t] = 1'b1;
        req_op[t*3 +: 3] = op[2:0];
    endtask

    // apply the staged inputs for one edge, then clear pulses
    task automatic fire();
        step();
        req_valid = '0;
        wake = '0;
    endtask

    task automatic wake_all();
        wake = '1;
        fire();
        for (int c = 0; c < NC; c++) chk("R9 core after wake", core_of(c), 0);
        chk("R9 pkg after wake", pkg_state, 0);
    endtask

    task automatic t_reset();
        for (int c = 0; c < NC; c++) chk("R1 core reset", core_of(c), 0);
        chk("R1 pkg reset", pkg_state, 0);
        chk("R1 snoop reset", llc_snoop, 1);
        chk("R1 strobe reset", pkg_chg, 0);
    endtask

    task automatic t_c1();
        wake_all();
        c1e_en = 1'b0; plat_allow = 2'd2;
        req(0, 0); fire();
        chk("R4 core0 one thread halted", core_of(0), 0);
        req(1, 1); fire();
        chk("R2 core0 C1", core_of(0), 1);
        c1e_en = 1'b1;
        req(2, 0); req(3, 1); fire();
        chk("R2 core1 C1E", core_of(1), 2);
        chk("R2 core0 unchanged", core_of(0), 1);
        for (int t = 4; t < NT; t++) req(t, 3);
        fire();
        chk("R3 core2 C6", core_of(2), 4);
        chk("R5 pkg C0 with C1 core", pkg_state, 0);
        chk("R8 snoop in C0", llc_snoop, 1);
        c1e_en = 1'b0;
    endtask

    task automatic t_ops();
        wake_all();
        plat_allow = 2'd2;
        req(0, 6); req(1, 2); fire();
        chk("R10 reserved op ignored", core_of(0), 0);
        req(0, 2); fire();
        chk("R3 WAIT_C3 core0", core_of(0), 3);
        req(2, 4); req(3, 5); fire();
        chk("R4 core1 min of C3,C6", core_of(1), 3);
        chk("R3 LEVEL2 read gives C3", core_of(1), 3);
        req(4, 7); fire();
        chk("R10 reserved op 7 ignored", core_of(2), 0);
    endtask

    task automatic t_pkg_c3();
        wake_all();
        plat_allow = 2'd2;
        for (int t = 0; t < 6; t++) req(t, 4);
        req(6, 3);
        fire();
        chk("R5 pkg C0 while core3 running", pkg_state, 0);
        req(7, 3); fire();
        chk("R6 pkg C3", pkg_state, 3);
        chk("R8 snoop in C3", llc_snoop, 1);
        chk("R11 strobe on entry", pkg_chg, 1);
        step();
        chk("R11 strobe single cycle", pkg_chg, 0);
        chk("R12 pkg holds", pkg_state, 3);
    endtask

    task automatic t_pkg_c6();
        wake_all();
        plat_allow = 2'd2;
        for (int t = 0; t < NT; t++) req(t, (t % 2 == 0) ? 3 : 5);
        fire();
        for (int c = 0; c < NC; c++) chk("R3 core C6", core_of(c), 4);
        chk("R7 pkg C6", pkg_state, 4);
        chk("R8 snoop off in C6", llc_snoop, 0);
        chk("R11 strobe C0->C6", pkg_chg, 1);
        req(0, 0); fire();
        chk("R10 request while idle ignored", core_of(0), 4);
        plat_allow = 2'd1; step();
        chk("R7 demote to C3", pkg_state, 3);
        chk("R8 snoop back on", llc_snoop, 1);
        chk("R11 strobe C6->C3", pkg_chg, 1);
        plat_allow = 2'd3; step();
        chk("R7 permit 3 gives C6", pkg_state, 4);
        wake[5] = 1'b1; fire();
        chk("R9 woken core2", core_of(2), 0);
        chk("R9 other core stays", core_of(0), 4);
        chk("R9 pkg C0 on wake", pkg_state, 0);
        chk("R11 strobe on wake", pkg_chg, 1);
        req(5, 3); fire();
        chk("R7 back to C6", pkg_state, 4);
        plat_allow = 2'd0; step();
        chk("R5 no permission C0", pkg_state, 0);
        chk("R5 cores stay deep", core_of(3), 4);
        plat_allow = 2'd2;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = '0; req_op = '0; wake = '0;
        c1e_en = 1'b0; plat_allow = 2'd0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_c1();
        t_ops();
        t_pkg_c3();
        t_pkg_c6();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule